// File: doc/BRIEF.md
# Watchpoint-Controlled Trace Ring Buffer

This block watches a processor from the side. Each clock cycle it can take one probe sample: either a value written to a chosen general-purpose register, or an access on the system bus. A bus sample is stored as its address together with its read or write direction. While recording is on, every sample is written into a circular trace memory along with a free-running timestamp. Once the memory is full, each new sample replaces the oldest one.

A set of programmable watchpoints compares each probe against a masked value. When a watchpoint matches, its action can switch recording on, switch recording off (which freezes the trace), or raise a sticky halt request to the processor. All configuration and all trace readout go through a separate debug-bus slave port that has no path through the system bus. The trace can therefore still be recovered when the processor or the system bus has hung. The recording state, the halt state, the wrap flag and the write pointer are each kept in three copies. A majority vote gives the value that is used, and every cycle all three copies are reloaded from the voted next state.

Top module: `trc_monitor`

## Requirements
- R1: When recording is on and a probe is valid, one entry is written at the write pointer and the pointer advances by one, modulo DEPTH. Probes that arrive while recording is off leave the pointer and the memory unchanged.
- R2: A register sample stores its value with source tag 0 and write bit 0. A bus sample stores its address with source tag 1 and its write bit (1 = write). The entry's meta word holds the source tag in bit 31, the write bit in bit 30, and the timestamp in bits 15:0. The timestamp is a counter that starts at 0 when reset is released and increments every cycle. If both probes are valid in the same cycle, only the register sample is stored.
- R3: When the buffer is full, a new entry overwrites the oldest one. The wrap flag is set the first time the pointer rolls from DEPTH-1 to 0, and it stays set until a pointer clear.
- R4: A matching watchpoint with action code 01 turns recording on. The sample that triggered the match is stored.
- R5: A matching watchpoint with action code 10 turns recording off. The sample that triggered the match is not stored. When a start and a stop occur in the same cycle, the stop wins.
- R6: A matching watchpoint with action code 11 sets halt_req. It stays set until control bit 2 is written, and it does not change the recording state.
- R7: A watchpoint matches only when all of these hold: its enable bit (config bit 0) is 1; the probe picked by its source bit (config bit 1: 0 = register, 1 = bus address) is valid; and ((probe XOR value) AND mask) == 0. Action code 00 has no effect.
- R8: Debug map. Address 0x00: a write to bit 0 starts recording, bit 1 stops it, bit 2 clears halt, and bit 3 clears the pointer and the wrap flag. A read returns the pointer in bits 7:0, wrap in bit 8, recording in bit 9 and halt in bit 10. Watchpoint k sits at 0x10+4k: offset +0 holds the config (the action code is in bits 3:2), +1 the value, +2 the mask. Entry i sits at 0x80+2i: offset +0 holds the data word, +1 the meta word. Read data appears one cycle after the request.
- R9: Reading an entry while recording is on returns the stored value and does not alter capture in that cycle.
- R10: A wrong value in any single copy of the triplicated pointer is outvoted: the status read shows the correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register write probe valid |
| reg_data | input | DW | Value written to the probed register |
| bus_valid | input | 1 | System-bus access probe valid |
| bus_addr | input | DW | Address of the bus access |
| bus_write | input | 1 | 1 = bus write, 0 = bus read |
| dbg_sel | input | 1 | Debug access request |
| dbg_write | input | 1 | 1 = debug write, 0 = debug read |
| dbg_addr | input | AW | Debug word address |
| dbg_wdata | input | DW | Debug write data |
| dbg_rdata | output | DW | Debug read data, one cycle after the request |
| halt_req | output | 1 | Sticky halt request to the processor |
| rec_active | output | 1 | Recording is on |

## Verification
The assertions assume that reset holds for at least one edge. They also assume that the debug port and the watchpoints are the only sources of start, stop and clear commands. The stop-priority and hold properties rely on each probe being presented for exactly one cycle and then dropped. The bench keeps to this: every probe is a single-cycle pulse, and debug writes never share a cycle with a probe, so the model's ordering of events stays unambiguous. Debug reads do share cycles with probes. Only one copy of the pointer is corrupted at a time, because the voter tolerates a single wrong copy.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_START = 2'b01,
    ACT_STOP  = 2'b10,
    ACT_HALT  = 2'b11
  } trc_act_e;

  localparam logic [1:0] FLD_CFG = 2'd0;
  localparam logic [1:0] FLD_VAL = 2'd1;
  localparam logic [1:0] FLD_MSK = 2'd2;
endpackage

// File: rtl/trc_vote.sv
module trc_vote #(
  parameter int          W   = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_a, q_b, q_c;

  // every copy reloads from the voted next state each cycle (scrubbing)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a <= RST;
      q_b <= RST;
      q_c <= RST;
    end else begin
      q_a <= d;
      q_b <= d;
      q_c <= d;
    end
  end

  always_comb q = (q_a & q_b) | (q_a & q_c) | (q_b & q_c);
endmodule

// File: rtl/trc_watch.sv
module trc_watch
  import trc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_cfg,
  input  logic          we_val,
  input  logic          we_msk,
  input  logic [DW-1:0] wdata,
  input  logic          reg_valid,
  input  logic [DW-1:0] reg_data,
  input  logic          bus_valid,
  input  logic [DW-1:0] bus_addr,
  output logic          hit,
  output trc_act_e      act,
  output logic [DW-1:0] rd_cfg,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] rd_msk
);
  logic          en_q, en_n;
  logic          src_q, src_n;
  trc_act_e      act_q, act_n;
  logic [DW-1:0] val_q, val_n;
  logic [DW-1:0] msk_q, msk_n;
  logic [DW-1:0] sample;
  logic          sample_vld;

  always_comb begin
    en_n  = en_q;
    src_n = src_q;
    act_n = act_q;
    val_n = val_q;
    msk_n = msk_q;
    if (we_cfg) begin
      en_n  = wdata[0];
      src_n = wdata[1];
      act_n = trc_act_e'(wdata[3:2]);
    end
    if (we_val) val_n = wdata;
    if (we_msk) msk_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      src_q <= 1'b0;
      act_q <= ACT_NONE;
      val_q <= '0;
      msk_q <= '0;
    end else begin
      en_q  <= en_n;
      src_q <= src_n;
      act_q <= act_n;
      val_q <= val_n;
      msk_q <= msk_n;
    end
  end

  always_comb begin
    sample     = src_q ? bus_addr  : reg_data;
    sample_vld = src_q ? bus_valid : reg_valid;
    hit        = en_q & sample_vld & (((sample ^ val_q) & msk_q) == '0);
    act        = act_q;
    rd_cfg     = {{(DW-4){1'b0}}, act_q, src_q, en_q};
    rd_val     = val_q;
    rd_msk     = msk_q;
  end

  // R7: an enabled register watchpoint with an all-zero mask fires on any register sample
  a_r7_zero_mask_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !src_q && msk_q == '0 && reg_valid) |-> hit);
  // R7: a hit needs the selected probe to be valid
  a_r7_needs_probe: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (reg_valid || bus_valid));
endmodule

// File: rtl/trc_store.sv
module trc_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int MW    = 18,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [MW-1:0] wmeta,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [MW-1:0] rmeta
);
  logic [DW-1:0] mem_d [DEPTH];
  logic [MW-1:0] mem_m [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_d[waddr] <= wdata;
      mem_m[waddr] <= wmeta;
    end
  end

  always_comb begin
    rdata = mem_d[raddr];
    rmeta = mem_m[raddr];
  end
endmodule

// File: rtl/trc_monitor.sv
module trc_monitor
  import trc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int NWP   = 2,
  parameter int TSW   = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_valid,
  input  logic [DW-1:0] reg_data,
  input  logic          bus_valid,
  input  logic [DW-1:0] bus_addr,
  input  logic          bus_write,
  input  logic          dbg_sel,
  input  logic          dbg_write,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata,
  output logic          halt_req,
  output logic          rec_active
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MW = TSW + 2;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  // ---------------- debug decode ----------------
  logic       dbg_wr, dbg_rd;
  logic       ctl_wr, wp_region, ent_region;
  logic [1:0] wp_idx, wp_fld;
  logic       cmd_start, cmd_stop, cmd_hclr, cmd_pclr;

  always_comb begin
    dbg_wr     = dbg_sel & dbg_write;
    dbg_rd     = dbg_sel & ~dbg_write;
    ctl_wr     = dbg_wr & (dbg_addr == '0);
    wp_region  = (dbg_addr[AW-1:4] == (AW-4)'(1));
    ent_region = dbg_addr[AW-1];
    wp_idx     = dbg_addr[3:2];
    wp_fld     = dbg_addr[1:0];
    cmd_start  = ctl_wr & dbg_wdata[0];
    cmd_stop   = ctl_wr & dbg_wdata[1];
    cmd_hclr   = ctl_wr & dbg_wdata[2];
    cmd_pclr   = ctl_wr & dbg_wdata[3];
  end

  // ---------------- watchpoints ----------------
  logic [NWP-1:0] wp_hit;
  trc_act_e       wp_act [NWP];
  logic [DW-1:0]  wp_cfg [NWP];
  logic [DW-1:0]  wp_val [NWP];
  logic [DW-1:0]  wp_msk [NWP];

  for (genvar k = 0; k < NWP; k++) begin : g_wp
    logic sel_k;
    always_comb sel_k = dbg_wr & wp_region & (wp_idx == 2'(k));
    trc_watch #(.DW(DW)) u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_cfg    (sel_k & (wp_fld == FLD_CFG)),
      .we_val    (sel_k & (wp_fld == FLD_VAL)),
      .we_msk    (sel_k & (wp_fld == FLD_MSK)),
      .wdata     (dbg_wdata),
      .reg_valid (reg_valid),
      .reg_data  (reg_data),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .hit       (wp_hit[k]),
      .act       (wp_act[k]),
      .rd_cfg    (wp_cfg[k]),
      .rd_val    (wp_val[k]),
      .rd_msk    (wp_msk[k])
    );
  end

  logic hit_start, hit_stop, hit_halt;
  always_comb begin
    hit_start = 1'b0;
    hit_stop  = 1'b0;
    hit_halt  = 1'b0;
    for (int k = 0; k < NWP; k++) begin
      if (wp_hit[k] && wp_act[k] == ACT_START) hit_start = 1'b1;
      if (wp_hit[k] && wp_act[k] == ACT_STOP)  hit_stop  = 1'b1;
      if (wp_hit[k] && wp_act[k] == ACT_HALT)  hit_halt  = 1'b1;
    end
  end

  // ---------------- voted control state ----------------
  logic          rec_q, halt_q, wrap_q;
  logic          rec_n, halt_n, wrap_n;
  logic [PW-1:0] wptr_q, wptr_n;
  logic          start_any, stop_any, cap;

  always_comb begin
    start_any = hit_start | cmd_start;
    stop_any  = hit_stop  | cmd_stop;
    rec_n     = (rec_q | start_any) & ~stop_any;
    cap       = rec_n & (reg_valid | bus_valid) & ~cmd_pclr;
    halt_n    = hit_halt ? 1'b1 : (cmd_hclr ? 1'b0 : halt_q);
    wptr_n    = wptr_q;
    wrap_n    = wrap_q;
    if (cmd_pclr) begin
      wptr_n = '0;
      wrap_n = 1'b0;
    end else if (cap) begin
      wptr_n = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (wptr_q == LAST) wrap_n = 1'b1;
    end
  end

  trc_vote #(.W(3), .RST(3'b000)) u_ctl_vote (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rec_n, halt_n, wrap_n}),
    .q     ({rec_q, halt_q, wrap_q})
  );

  trc_vote #(.W(PW), .RST('0)) u_ptr_vote (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (wptr_n),
    .q     (wptr_q)
  );

  // ---------------- timestamp ----------------
  logic [TSW-1:0] ts_q, ts_n;
  always_comb ts_n = ts_q + 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_n;
  end

  // ---------------- entry storage ----------------
  logic [DW-1:0] ent_data, rd_data;
  logic [MW-1:0] ent_meta, rd_meta;

  always_comb begin
    ent_data = reg_valid ? reg_data : bus_addr;
    ent_meta = {~reg_valid, ~reg_valid & bus_write, ts_q};
  end

  trc_store #(.DEPTH(DEPTH), .DW(DW), .MW(MW)) u_store (
    .clk   (clk),
    .we    (cap),
    .waddr (wptr_q),
    .wdata (ent_data),
    .wmeta (ent_meta),
    .raddr (dbg_addr[PW:1]),
    .rdata (rd_data),
    .rmeta (rd_meta)
  );

  // ---------------- debug read ----------------
  logic [DW-1:0] rd_n, rdata_q, status;

  always_comb begin
    status           = '0;
    status[PW-1:0]   = wptr_q;
    status[8]        = wrap_q;
    status[9]        = rec_q;
    status[10]       = halt_q;
    rd_n = '0;
    if (dbg_addr == '0) begin
      rd_n = status;
    end else if (wp_region) begin
      for (int k = 0; k < NWP; k++) begin
        if (wp_idx == 2'(k)) begin
          case (wp_fld)
            FLD_CFG: rd_n = wp_cfg[k];
            FLD_VAL: rd_n = wp_val[k];
            FLD_MSK: rd_n = wp_msk[k];
            default: rd_n = '0;
          endcase
        end
      end
    end else if (ent_region) begin
      rd_n = dbg_addr[0]
           ? {rd_meta[MW-1:MW-2], {(DW-MW){1'b0}}, rd_meta[TSW-1:0]}
           : rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (dbg_rd) rdata_q <= rd_n;
  end

  always_comb begin
    dbg_rdata  = rdata_q;
    halt_req   = halt_q;
    rec_active = rec_q;
  end

  // ---------------- assertions ----------------
  // R1: no probe and no control write -> pointer holds
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_valid && !bus_valid && !ctl_wr) |=> $stable(wptr_q));
  // R3: wrap flag is sticky until a pointer clear
  a_r3_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !cmd_pclr) |=> wrap_q);
  // R4: a start match without a stop turns recording on
  a_r4_start_on: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_start && !stop_any) |=> rec_active);
  // R5: any stop wins
  a_r5_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stop_any |=> !rec_active);
  // R6: halt match raises the request
  a_r6_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit_halt |=> halt_req);
  // R6: halt request holds until cleared through the debug port
  a_r6_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !cmd_hclr) |=> halt_req);
  // R1: recording off and no start -> pointer holds
  a_r1_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_active && !start_any && !ctl_wr) |=> $stable(wptr_q));
endmodule

// File: tb/trc_monitor_bench.sv
module trc_monitor_bench;
  localparam int DW = 32, DEPTH = 8, NWP = 2, TSW = 16, AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_valid, bus_valid, bus_write;
  logic [DW-1:0] reg_data, bus_addr;
  logic          dbg_sel, dbg_write;
  logic [AW-1:0] dbg_addr;
  logic [DW-1:0] dbg_wdata, dbg_rdata;
  logic          halt_req, rec_active;

  trc_monitor #(.DW(DW), .DEPTH(DEPTH), .NWP(NWP), .TSW(TSW), .AW(AW)) u_trc_monitor (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_data(reg_data),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
    .dbg_sel(dbg_sel), .dbg_write(dbg_write), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .halt_req(halt_req), .rec_active(rec_active)
  );

  always #10 clk = ~clk;

  logic [31:0] cyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  int nchk = 0, nfail = 0;

  // model
  logic [31:0] e_data [DEPTH];
  logic [31:0] e_meta [DEPTH];
  int   m_wptr = 0;
  bit   m_wrap = 0, m_rec = 0, m_halt = 0;
  bit          c_en  [NWP];
  bit          c_src [NWP];
  logic [1:0]  c_act [NWP];
  logic [31:0] c_val [NWP];
  logic [31:0] c_msk [NWP];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic dbg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    dbg_sel = 1; dbg_write = 1; dbg_addr = a; dbg_wdata = d;
    if (a == 8'h00) begin
      if (d[3]) begin m_wptr = 0; m_wrap = 0; end
      m_rec = (m_rec || d[0]) && !d[1];
      if (d[2]) m_halt = 0;
    end else if (a[7:4] == 4'h1 && a[3:2] < NWP) begin
      case (a[1:0])
        2'd0: begin c_en[a[3:2]] = d[0]; c_src[a[3:2]] = d[1]; c_act[a[3:2]] = d[3:2]; end
        2'd1: c_val[a[3:2]] = d;
        2'd2: c_msk[a[3:2]] = d;
        default: ;
      endcase
    end
    @(posedge clk); #1;
    dbg_sel = 0; dbg_write = 0;
  endtask

  task automatic dbg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    dbg_sel = 1; dbg_write = 0; dbg_addr = a;
    @(posedge clk); #1;
    dbg_sel = 0;
    d = dbg_rdata;
  endtask

  task automatic step(input bit rv, input logic [31:0] rd, input bit bv,
                      input logic [31:0] ba, input bit bw);
    bit st, sp, hl, rn, h;
    st = 0; sp = 0; hl = 0;
    @(negedge clk);
    reg_valid = rv; reg_data = rd; bus_valid = bv; bus_addr = ba; bus_write = bw;
    for (int k = 0; k < NWP; k++) begin
      h = c_en[k] && (c_src[k] ? (bv && (((ba ^ c_val[k]) & c_msk[k]) == 0))
                               : (rv && (((rd ^ c_val[k]) & c_msk[k]) == 0)));
      if (h && c_act[k] == 2'b01) st = 1;
      if (h && c_act[k] == 2'b10) sp = 1;
      if (h && c_act[k] == 2'b11) hl = 1;
    end
    rn = (m_rec || st) && !sp;
    if (rn && (rv || bv)) begin
      e_data[m_wptr] = rv ? rd : ba;
      e_meta[m_wptr] = {(rv ? 1'b0 : 1'b1), (rv ? 1'b0 : bw), 14'b0, cyc[15:0]};
      m_wptr = (m_wptr + 1) % DEPTH;
      if (m_wptr == 0) m_wrap = 1;
    end
    m_rec = rn;
    if (hl) m_halt = 1;
    @(posedge clk); #1;
    reg_valid = 0; bus_valid = 0;
  endtask

  function automatic logic [31:0] exp_status();
    return 32'(m_wptr) | (32'(m_wrap) << 8) | (32'(m_rec) << 9) | (32'(m_halt) << 10);
  endfunction

  task automatic chk_status(input string req);
    logic [31:0] d;
    dbg_rd(8'h00, d);
    chk(req, d, exp_status());
    chk(req, {31'b0, halt_req}, {31'b0, m_halt});
    chk(req, {31'b0, rec_active}, {31'b0, m_rec});
  endtask

  task automatic chk_entries(input string req);
    logic [31:0] d;
    int n;
    n = m_wrap ? DEPTH : m_wptr;
    for (int i = 0; i < n; i++) begin
      dbg_rd(8'h80 + 8'(2*i), d);
      chk(req, d, e_data[i]);
      dbg_rd(8'h81 + 8'(2*i), d);
      chk(req, d, e_meta[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d, expd;
    for (int k = 0; k < NWP; k++) begin
      c_en[k] = 0; c_src[k] = 0; c_act[k] = 0; c_val[k] = 0; c_msk[k] = 0;
    end
    rst_n = 0; reg_valid = 0; bus_valid = 0; bus_write = 0; reg_data = 0; bus_addr = 0;
    dbg_sel = 0; dbg_write = 0; dbg_addr = 0; dbg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // reset state (R1, R8)
    chk_status("R8 reset");

    // R1: probes ignored while idle
    for (int i = 0; i < 3; i++) step(1, 32'h10 + 32'(i), 1, 32'h900, 1);
    chk_status("R1 idle ignores probes");

    // R8 start command, R1/R2/R3 fill past full
    dbg_wr(8'h00, 32'h1);
    chk_status("R8 start command");
    for (int i = 0; i < 11; i++) step(1, 32'h100 + 32'(i), 0, 0, 0);
    step(1, 32'h200, 1, 32'h300, 1);          // R2 register sample wins
    dbg_wr(8'h00, 32'h2);
    chk_status("R3 wrap and pointer");
    chk_entries("R3 R2 overwrite contents");

    // R10: one corrupted pointer copy is outvoted
    force u_trc_monitor.u_ptr_vote.q_b = '0;
    chk_status("R10 single copy upset");
    release u_trc_monitor.u_ptr_vote.q_b;
    step(0, 0, 0, 0, 0);
    chk_status("R10 after scrub");

    // watchpoints: wp0 register start masked, wp1 bus stop
    dbg_wr(8'h00, 32'h8);
    dbg_wr(8'h10, 32'h5);
    dbg_wr(8'h11, 32'hABCD0000);
    dbg_wr(8'h12, 32'hFFFF0000);
    dbg_wr(8'h14, 32'hB);
    dbg_wr(8'h15, 32'h4000);
    dbg_wr(8'h16, 32'hFFFFFFFF);
    dbg_rd(8'h10, d); chk("R8 wp cfg readback", d, 32'h5);
    dbg_rd(8'h11, d); chk("R8 wp value readback", d, 32'hABCD0000);
    dbg_rd(8'h16, d); chk("R8 wp mask readback", d, 32'hFFFFFFFF);
    chk_status("R8 pointer clear");

    step(1, 32'h12340000, 0, 0, 0);           // R7 no match
    chk_status("R7 mismatch no start");
    step(1, 32'hABCD1234, 0, 0, 0);           // R4 start, recorded
    chk_status("R4 start by watchpoint");
    step(0, 0, 1, 32'h1000, 0);
    step(0, 0, 1, 32'h2000, 1);
    step(1, 32'h55, 0, 0, 0);
    step(0, 0, 1, 32'h4000, 1);               // R5 stop, not recorded
    step(1, 32'h66, 0, 0, 0);
    chk_status("R5 stop freezes");
    chk_entries("R2 R4 entries");

    // R7 disabled watchpoint
    dbg_wr(8'h10, 32'h4);
    step(1, 32'hABCD9999, 0, 0, 0);
    chk_status("R7 disabled watchpoint");

    // R5 start and stop same cycle
    dbg_wr(8'h10, 32'h5);
    step(1, 32'hABCD0001, 1, 32'h4000, 0);
    chk_status("R5 stop beats start");

    // R6 halt
    dbg_wr(8'h14, 32'hF);
    step(0, 0, 1, 32'h4000, 0);
    chk("R6 halt raised", {31'b0, halt_req}, 32'h1);
    for (int i = 0; i < 3; i++) step(1, 32'h77, 0, 0, 0);
    chk_status("R6 halt held recording untouched");
    dbg_wr(8'h00, 32'h4);
    chk_status("R6 halt cleared");

    // R9 read entries while capturing
    dbg_wr(8'h00, 32'h1);
    for (int j = 0; j < 4; j++) begin
      expd = e_data[j];
      dbg_sel = 1; dbg_write = 0; dbg_addr = 8'h80 + 8'(2*j);
      step(1, 32'hC00 + 32'(j), 0, 0, 0);
      dbg_sel = 0;
      chk("R9 read during capture", dbg_rdata, expd);
    end
    chk_status("R9 capture undisturbed");
    chk_entries("R9 R3 contents");

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule